// File: doc/BRIEF.md
# Coherent Byte-Pair Register Write Buffer

This block keeps a bank of 16-bit registers that software reaches through an 8-bit write port. A byte written to one half of a register is parked in a holding byte for that half. The register takes a new 16-bit value only when the other half has also been written. Either half may go first. As a result, the register never shows a value with one old byte and one new byte.

A freeze input models a halted debug session. While it is high, byte writes go straight into the addressed register half. The holding bytes and the record of which halves are waiting do not change. A sequence that was half done before the freeze can therefore be finished afterwards. A separate clear strobe drops any waiting half of one register, but only while the extended-mode input is low.

The write port is a valid/ready stream. `wr_ready` is tied high, so the block never applies back-pressure and takes one byte on every cycle in which `wr_valid` is high. Clear, freeze and mode inputs are plain level or strobe signals.

Top module: `cbw_top`

## Requirements
- R1: After reset every register reads 0x0000, and every holding byte and waiting flag is clear.
- R2: In normal mode, a byte write to a half when the other half is not waiting leaves the register unchanged. That byte is held for later.
- R3: In normal mode, a byte write to one half while the other half is waiting loads the register with both bytes at that clock edge. The value is visible from the next cycle, and both waiting flags clear.
- R4: High-then-low and low-then-high sequences carrying the same bytes give the same register value.
- R5: Writing the same half twice before the other half replaces the held byte and commits nothing.
- R6: While `dbg_freeze` is high, a byte write updates the addressed half of the register directly at that edge. The value remains after the freeze ends, until a later commit overwrites it.
- R7: While `dbg_freeze` is high, the holding bytes and waiting flags do not change. After the freeze, completing a waiting sequence commits the byte held before the freeze.
- R8: A `clr_valid` pulse with `ext_mode` low drops the waiting halves of register `clr_idx`. With `ext_mode` high, the pulse has no effect.
- R9: `rd_data` returns the committed register byte selected by `rd_addr`, never a held byte. Address bit 0 selects the high byte when 1 and the low byte when 0. The upper bits give the register index, and the same encoding applies to `wr_addr`.
- R10: A write to one register never changes another register.
- R11: `wr_ready` is always 1, so every cycle with `wr_valid` high consumes one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Byte write request |
| wr_ready | output | 1 | Always 1; the block never stalls |
| wr_addr | input | IDX_W+1 | Register index and half select (bit 0: 1 = high) |
| wr_data | input | 8 | Byte to write |
| rd_addr | input | IDX_W+1 | Read address, same encoding |
| rd_data | output | 8 | Committed byte at rd_addr |
| dbg_freeze | input | 1 | Debug freeze: direct writes, buffer held |
| ext_mode | input | 1 | When 1, clear strobes are ignored |
| clr_valid | input | 1 | Clear strobe for waiting halves |
| clr_idx | input | IDX_W | Register index for the clear strobe |
| val_q | output | 16*NUM_REGS | All committed registers, register i at [16i+15:16i] |

## Verification
A waiting flag that is set wrongly shows up at the ports on the very next write to the other half. That write either commits when it should not, or fails to commit. The fault is therefore visible on `val_q` one cycle after that write. A held byte that is lost or overwritten during a freeze stays hidden until the sequence is completed. Only then does the wrong byte appear in the committed value. For this reason, the bench finishes sequences that span a freeze and compares every register against a behavioural model on every cycle.

// File: rtl/cbw_pkg.sv
package cbw_pkg;
  typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_e;
  typedef struct packed {
    logic hi;
    logic lo;
  } wait_t;
endpackage

// File: rtl/cbw_decode.sv
module cbw_decode #(
  parameter int NUM_REGS = 4,
  parameter int IDX_W = 2
) (
  input  logic                wr_valid,
  input  logic [IDX_W:0]      wr_addr,
  input  logic                clr_valid,
  input  logic [IDX_W-1:0]    clr_idx,
  input  logic                ext_mode,
  output logic [NUM_REGS-1:0] sel_hi,
  output logic [NUM_REGS-1:0] sel_lo,
  output logic [NUM_REGS-1:0] sel_clr
);
  import cbw_pkg::*;
  logic [IDX_W-1:0] idx;
  half_e            half;
  assign idx  = wr_addr[IDX_W:1];
  assign half = half_e'(wr_addr[0]);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign sel_hi[i]  = wr_valid && (idx == IDX_W'(i)) && (half == HALF_HI);
    assign sel_lo[i]  = wr_valid && (idx == IDX_W'(i)) && (half == HALF_LO);
    assign sel_clr[i] = clr_valid && !ext_mode && (clr_idx == IDX_W'(i));
  end
endmodule

// File: rtl/cbw_lane.sv
module cbw_lane (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dbg,
  input  logic        wr_hi,
  input  logic        wr_lo,
  input  logic        clr,
  input  logic [7:0]  wdata,
  output logic [15:0] value,
  output cbw_pkg::wait_t waiting
);
  import cbw_pkg::*;
  logic [7:0] hold_hi, hold_lo;
  wait_t      eff;

  always_comb begin
    eff = clr ? '0 : waiting;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value   <= '0;
      hold_hi <= '0;
      hold_lo <= '0;
      waiting <= '0;
    end else if (dbg) begin
      if (wr_hi) value[15:8] <= wdata;
      if (wr_lo) value[7:0]  <= wdata;
      if (clr)   waiting     <= '0;
    end else if (wr_hi) begin
      if (eff.lo) begin
        value   <= {wdata, hold_lo};
        waiting <= '0;
      end else begin
        hold_hi <= wdata;
        waiting <= '{hi: 1'b1, lo: 1'b0};
      end
    end else if (wr_lo) begin
      if (eff.hi) begin
        value   <= {hold_hi, wdata};
        waiting <= '0;
      end else begin
        hold_lo <= wdata;
        waiting <= '{hi: 1'b0, lo: 1'b1};
      end
    end else if (clr) begin
      waiting <= '0;
    end
  end
endmodule

// File: rtl/cbw_top.sv
module cbw_top #(
  parameter int NUM_REGS = 4,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [IDX_W:0]         wr_addr,
  input  logic [7:0]             wr_data,
  input  logic [IDX_W:0]         rd_addr,
  output logic [7:0]             rd_data,
  input  logic                   dbg_freeze,
  input  logic                   ext_mode,
  input  logic                   clr_valid,
  input  logic [IDX_W-1:0]       clr_idx,
  output logic [16*NUM_REGS-1:0] val_q
);
  import cbw_pkg::*;
  logic [NUM_REGS-1:0] sel_hi, sel_lo, sel_clr;
  logic [NUM_REGS-1:0] wait_hi, wait_lo;
  logic [15:0]         regs [NUM_REGS];

  assign wr_ready = 1'b1;

  cbw_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
    .wr_valid(wr_valid), .wr_addr(wr_addr), .clr_valid(clr_valid),
    .clr_idx(clr_idx), .ext_mode(ext_mode),
    .sel_hi(sel_hi), .sel_lo(sel_lo), .sel_clr(sel_clr)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_lane
    wait_t w;
    cbw_lane u_lane (
      .clk(clk), .rst_n(rst_n), .dbg(dbg_freeze),
      .wr_hi(sel_hi[i]), .wr_lo(sel_lo[i]), .clr(sel_clr[i]),
      .wdata(wr_data), .value(regs[i]), .waiting(w)
    );
    assign wait_hi[i] = w.hi;
    assign wait_lo[i] = w.lo;
    assign val_q[16*i +: 16] = regs[i];
  end

  logic [IDX_W-1:0] rd_idx;
  logic [15:0]      rd_word;
  assign rd_idx = rd_addr[IDX_W:1];

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == IDX_W'(i)) rd_word = regs[i];
  end

  assign rd_data = rd_addr[0] ? rd_word[15:8] : rd_word[7:0];
endmodule

// File: rtl/cbw_chk.sv
module cbw_chk #(
  parameter int NUM_REGS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_ready,
  input logic                   dbg_freeze,
  input logic [7:0]             wr_data,
  input logic [NUM_REGS-1:0]    sel_hi,
  input logic [NUM_REGS-1:0]    sel_lo,
  input logic [NUM_REGS-1:0]    sel_clr,
  input logic [NUM_REGS-1:0]    wait_hi,
  input logic [NUM_REGS-1:0]    wait_lo,
  input logic [16*NUM_REGS-1:0] val_q
);
  always_comb begin
    if (rst_n) AST_READY_HIGH: assert (wr_ready == 1'b1); // R11
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    AST_WAIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wait_hi[i] && wait_lo[i])); // R3
    AST_FIRST_HALF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbg_freeze && sel_hi[i] && !wait_lo[i]) |=> $stable(val_q[16*i +: 16])); // R2
    AST_COMMIT_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbg_freeze && sel_hi[i] && wait_lo[i] && !sel_clr[i])
      |=> (val_q[16*i+8 +: 8] == $past(wr_data)) && !wait_lo[i]); // R3
    AST_FREEZE_HOLDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_freeze && !sel_clr[i]) |=> $stable(wait_hi[i]) && $stable(wait_lo[i])); // R7
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_clr[i] && !sel_hi[i] && !sel_lo[i]) |=> !wait_hi[i] && !wait_lo[i]); // R8
    AST_OTHER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_hi[i] && !sel_lo[i]) |=> $stable(val_q[16*i +: 16])); // R10
  end
endmodule

bind cbw_top cbw_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .dbg_freeze(dbg_freeze),
  .wr_data(wr_data), .sel_hi(sel_hi), .sel_lo(sel_lo), .sel_clr(sel_clr),
  .wait_hi(wait_hi), .wait_lo(wait_lo), .val_q(val_q)
);

// File: tb/sim_cbw_top.sv
module sim_cbw_top;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, dbg_freeze = 0, ext_mode = 0, clr_valid = 0;
  logic [IW:0] wr_addr = '0, rd_addr = '0;
  logic [IW-1:0] clr_idx = '0;
  logic [7:0] wr_data = '0;
  logic wr_ready;
  logic [7:0] rd_data;
  logic [16*N-1:0] val_q;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_val [N];
  int m_hh [N];
  int m_hl [N];
  bit m_wh [N];
  bit m_wl [N];

  always #10 clk = ~clk;

  cbw_top #(.NUM_REGS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .dbg_freeze(dbg_freeze), .ext_mode(ext_mode), .clr_valid(clr_valid),
    .clr_idx(clr_idx), .val_q(val_q)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model, updated on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_val[i] = 0; m_hh[i] = 0; m_hl[i] = 0; m_wh[i] = 0; m_wl[i] = 0;
      end
    end else begin
      int k;
      k = int'(wr_addr >> 1);
      if (clr_valid && !ext_mode) begin
        m_wh[clr_idx] = 0; m_wl[clr_idx] = 0;
      end
      if (wr_valid) begin
        if (dbg_freeze) begin
          if (wr_addr[0]) m_val[k] = (m_val[k] & 'hff) | (int'(wr_data) << 8);
          else            m_val[k] = (m_val[k] & 'hff00) | int'(wr_data);
        end else if (wr_addr[0]) begin
          if (m_wl[k]) begin m_val[k] = (int'(wr_data) << 8) | m_hl[k]; m_wl[k] = 0; m_wh[k] = 0; end
          else begin m_hh[k] = wr_data; m_wh[k] = 1; end
        end else begin
          if (m_wh[k]) begin m_val[k] = (m_hh[k] << 8) | int'(wr_data); m_wl[k] = 0; m_wh[k] = 0; end
          else begin m_hl[k] = wr_data; m_wl[k] = 1; end
        end
      end
    end
  end

  // compare every register and the read port against the model each cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e;
      #2;
      for (int i = 0; i < N; i++)
        chk(int'(val_q[16*i +: 16]) == m_val[i], "R3 model", int'(val_q[16*i +: 16]), m_val[i]);
      e = m_val[int'(rd_addr >> 1)];
      e = rd_addr[0] ? (e >> 8) : (e & 'hff);
      chk(int'(rd_data) == e, "R9 model", int'(rd_data), e);
    end
  end

  task automatic wr(input int idx, input bit hi, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1; wr_addr = {IW'(idx), hi}; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic clear(input int idx);
    @(negedge clk);
    clr_valid = 1; clr_idx = IW'(idx);
    @(negedge clk);
    clr_valid = 0;
  endtask

  function automatic int regv(input int idx);
    return int'(val_q[16*idx +: 16]);
  endfunction

  task automatic rd_chk(input int idx, input bit hi, input int exp, input string req);
    rd_addr = {IW'(idx), hi};
    #1;
    chk(int'(rd_data) == exp, req, int'(rd_data), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < N; i++) chk(regv(i) == 0, "R1", regv(i), 0);
    chk(wr_ready == 1'b1, "R11", int'(wr_ready), 1);

    wr(0, 1, 8'hAB);
    chk(regv(0) == 0, "R2", regv(0), 0);
    rd_chk(0, 1, 0, "R9 held byte not readable");
    wr(0, 0, 8'hCD);
    chk(regv(0) == 'hABCD, "R3", regv(0), 'hABCD);

    wr(1, 0, 8'h34);
    wr(1, 1, 8'h12);
    chk(regv(1) == 'h1234, "R4", regv(1), 'h1234);

    wr(2, 1, 8'h11);
    wr(2, 1, 8'h22);
    chk(regv(2) == 0, "R5", regv(2), 0);
    wr(2, 0, 8'h33);
    chk(regv(2) == 'h2233, "R5", regv(2), 'h2233);
    chk(regv(0) == 'hABCD, "R10", regv(0), 'hABCD);

    wr(3, 1, 8'h55);
    dbg_freeze = 1;
    wr(3, 0, 8'h77);
    chk(regv(3) == 'h0077, "R6", regv(3), 'h0077);
    wr(3, 1, 8'h66);
    chk(regv(3) == 'h6677, "R6", regv(3), 'h6677);
    dbg_freeze = 0;
    @(negedge clk);
    chk(regv(3) == 'h6677, "R6 kept after freeze", regv(3), 'h6677);
    wr(3, 0, 8'h99);
    chk(regv(3) == 'h5599, "R7", regv(3), 'h5599);

    ext_mode = 0;
    wr(0, 1, 8'hEE);
    clear(0);
    wr(0, 0, 8'hFF);
    chk(regv(0) == 'hABCD, "R8 clear drops", regv(0), 'hABCD);
    wr(0, 1, 8'h01);
    chk(regv(0) == 'h01FF, "R8", regv(0), 'h01FF);

    ext_mode = 1;
    wr(1, 1, 8'hAA);
    clear(1);
    wr(1, 0, 8'hBB);
    chk(regv(1) == 'hAABB, "R8 ignored in ext mode", regv(1), 'hAABB);

    rd_chk(1, 0, 'hBB, "R9");
    rd_chk(1, 1, 'hAA, "R9");
    chk(wr_ready == 1'b1, "R11", int'(wr_ready), 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule